// File: doc/BRIEF.md
# Slice-Based Variable-Wordlength Multiply-Accumulate Unit

This block multiplies a signed activation by a signed weight and adds the product into a running accumulator. The weight wordlength can change at run time, from 1 bit up to a maximum set at elaboration. Inside the block the weight is cut into fixed-width slices. Each slice drives its own partial-product generator. For any one operation only as many generators as the current wordlength needs, ceil(wordlength / slice width), do any work. The generators that are not needed keep their registers frozen, so they do not toggle.

The wordlength comes from a small table indexed by a layer or channel number that arrives with each operand. The table is written through a plain address/data/write-enable port. A clear flag that travels with an operand starts a new sum with that operand's product. The accumulator saturates at its signed limits and sets a sticky overflow flag. The result appears two cycles after the operand is accepted, and a one-cycle valid pulse marks it.

Top module: `slice_mac`

## Requirements
- R1: After reset the accumulator reads 0, the overflow flag is 0, the result-valid pulse is low, and the operand-ready output is high from the first clock edge after reset is released.
- R2: The weight is the low wordlength bits of the weight input, read as two's complement. Weight input bits at or above the wordlength have no effect on the product. The activation is an 8-bit two's complement value.
- R3: Every table entry resets to the maximum wordlength (8). A written value of 0 is stored as 1, and a value above the maximum is stored as the maximum. A table write takes effect for operands accepted in the cycle after the write.
- R4: Exactly ceil(wordlength / slice width) slice generators are enabled for an accepted operand, and slice 0 is always one of them. A generator that is not enabled holds its partial-product register unchanged.
- R5: When an operand is accepted in cycle t, the accumulator and the result-valid pulse change in cycle t+2, and the pulse lasts one cycle. Operands accepted in back-to-back cycles are all accumulated, in order.
- R6: An operand with its clear flag set discards the previous sum, and the accumulator becomes that operand's product alone.
- R7: The accumulator never wraps. A sum above the largest signed ACC_W-bit value gives that largest value, and a sum below the smallest gives the smallest.
- R8: The overflow flag rises with the first saturating update and stays high until reset or until a clear operand that does not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand |
| in_act | input | ACT_W (8) | Signed activation |
| in_wgt | input | MAX_WQ (8) | Weight bits; the low wordlength bits are used |
| in_idx | input | IDX_W (4) | Layer/channel index into the wordlength table |
| in_clear | input | 1 | Start a new sum with this operand |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | IDX_W (4) | Table entry to write |
| cfg_wq | input | WQ_W (4) | Wordlength to store |
| acc_out | output | ACC_W (32) | Accumulated sum |
| acc_valid | output | 1 | One-cycle pulse: acc_out was just updated |
| acc_ovf | output | 1 | Sticky saturation flag |

## Verification
The bench drives weights whose bits above the active wordlength are set to junk. A design that read those bits, or that treated the top active slice as unsigned, would give wrong products and wrong signs. It writes the table and issues an operand on the very next cycle, which exposes a table read that lags by one write. It also writes the values 0 and 15, so a missing clamp would produce a zero-slice product or an out-of-range one. A long run of large same-sign products pushes the accumulator to both limits, which catches wrapping, and a later clear shows whether the overflow flag is sticky and whether it is released correctly. Every result is compared against its acceptance cycle plus two, so a missing or extra pipeline stage shows up as a timing mismatch.

// File: rtl/slice_mac_pkg.sv
package slice_mac_pkg;
  // Number of k-bit slices needed to cover a wordlength
  function automatic int unsigned slices_for(input int unsigned wq, input int unsigned k);
    return (wq + k - 1) / k;
  endfunction

  // Clamp a requested wordlength into 1..maxw
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned maxw);
    if (req == 0) return 1;
    if (req > maxw) return maxw;
    return req;
  endfunction
endpackage

// File: rtl/wq_lut.sv
module wq_lut #(
  parameter int DEPTH  = 16,
  parameter int MAX_WQ = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int WQ_W  = $clog2(MAX_WQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [WQ_W-1:0]  wr_len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WQ_W-1:0]  rd_len
);
  import slice_mac_pkg::*;

  logic [WQ_W-1:0] tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) tbl[e] <= WQ_W'(MAX_WQ);
    end else if (wr_en) begin
      tbl[wr_addr] <= WQ_W'(clamp_len(int'(wr_len), MAX_WQ));
    end
  end

  assign rd_len = tbl[rd_idx];

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len >= WQ_W'(1)) && (rd_len <= WQ_W'(MAX_WQ)));
endmodule

// File: rtl/slice_ppg.sv
module slice_ppg #(
  parameter int ACT_W   = 8,
  parameter int SLICE_W = 2,
  localparam int PP_W   = ACT_W + SLICE_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   is_top,
  input  logic signed [ACT_W-1:0] act,
  input  logic [SLICE_W-1:0]     bits,
  output logic signed [PP_W-1:0] pp_q
);
  // Slice operand: top slice sign-extended, lower slices zero-extended
  function automatic logic signed [SLICE_W:0] slice_operand(
    input logic [SLICE_W-1:0] b, input logic top);
    return top ? {b[SLICE_W-1], b} : {1'b0, b};
  endfunction

  logic signed [SLICE_W:0] opnd;
  logic signed [PP_W-1:0]  prod;

  assign opnd = slice_operand(bits, is_top);
  assign prod = act * opnd;

  always_ff @(posedge clk) begin
    if (!rst_n)  pp_q <= '0;
    else if (en) pp_q <= prod;
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pp_q));
endmodule

// File: rtl/acc_sat.sv
module acc_sat #(
  parameter int ACC_W = 32,
  parameter int SUM_W = 18,
  localparam int WIDE = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    clr,
  input  logic signed [SUM_W-1:0] addend,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    ovf_q,
  output logic                    valid_q
);
  localparam logic signed [WIDE-1:0] HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] LO = {3'b111, {(ACC_W-1){1'b0}}};

  function automatic logic signed [WIDE-1:0] wide_sum(
    input logic signed [ACC_W-1:0] base, input logic signed [SUM_W-1:0] a);
    logic signed [WIDE-1:0] wb, wa;
    wb = WIDE'(base);
    wa = WIDE'(a);
    return wb + wa;
  endfunction

  function automatic logic signed [ACC_W-1:0] clip(input logic signed [WIDE-1:0] s);
    if (s > HI) return HI[ACC_W-1:0];
    if (s < LO) return LO[ACC_W-1:0];
    return s[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] base;
  logic signed [WIDE-1:0]  raw;
  logic                    sat_hit;

  assign base    = clr ? '0 : acc_q;
  assign raw     = wide_sum(base, addend);
  assign sat_hit = (raw > HI) || (raw < LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd;
      if (upd) begin
        acc_q <= clip(raw);
        ovf_q <= (clr ? 1'b0 : ovf_q) | sat_hit;
      end
    end
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && addend >= 0) |=> (acc_q >= $past(acc_q)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(upd && clr)) |=> ovf_q);
  // R6
  clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clr) |=> (acc_q == ACC_W'($past(addend))));
  // R5
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> valid_q);
endmodule

// File: rtl/slice_mac.sv
module slice_mac #(
  parameter int SLICE_W = 2,
  parameter int MAX_WQ  = 8,
  parameter int ACT_W   = 8,
  parameter int ACC_W   = 32,
  parameter int DEPTH   = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WQ_W   = $clog2(MAX_WQ + 1),
  localparam int NS     = (MAX_WQ + SLICE_W - 1) / SLICE_W,
  localparam int EXT_W  = NS * SLICE_W,
  localparam int PP_W   = ACT_W + SLICE_W + 1,
  localparam int SUM_W  = ACT_W + EXT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [ACT_W-1:0] in_act,
  input  logic [MAX_WQ-1:0]       in_wgt,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic                    in_clear,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_addr,
  input  logic [WQ_W-1:0]         cfg_wq,
  output logic signed [ACC_W-1:0] acc_out,
  output logic                    acc_valid,
  output logic                    acc_ovf
);
  import slice_mac_pkg::*;

  // Sign-extend the low wq bits of w to the full slice span
  function automatic logic [EXT_W-1:0] widen_weight(
    input logic [MAX_WQ-1:0] w, input logic [WQ_W-1:0] wq);
    logic [EXT_W-1:0] r;
    for (int b = 0; b < EXT_W; b++) begin
      if (b < int'(wq)) r[b] = w[b];
      else              r[b] = w[int'(wq) - 1];
    end
    return r;
  endfunction

  logic                 ready_q;
  logic                 fire;
  logic [WQ_W-1:0]      cur_wq;
  int unsigned          nslices;
  logic [EXT_W-1:0]     wext;
  logic [NS-1:0]        slice_en;
  logic [NS-1:0]        slice_top;
  logic signed [PP_W-1:0] pp_q [NS];

  logic                 s1_vld;
  logic                 s1_clr;
  logic [NS-1:0]        s1_mask;
  logic signed [SUM_W-1:0] prod_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign fire     = in_valid && ready_q;

  wq_lut #(.DEPTH(DEPTH), .MAX_WQ(MAX_WQ)) u_lut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_len(cfg_wq),
    .rd_idx(in_idx), .rd_len(cur_wq)
  );

  assign nslices = slices_for(int'(cur_wq), SLICE_W);
  assign wext    = widen_weight(in_wgt, cur_wq);

  for (genvar i = 0; i < NS; i++) begin : g_slice
    assign slice_en[i]  = fire && (i < nslices);
    assign slice_top[i] = (i == nslices - 1);
    slice_ppg #(.ACT_W(ACT_W), .SLICE_W(SLICE_W)) u_ppg (
      .clk(clk), .rst_n(rst_n),
      .en(slice_en[i]), .is_top(slice_top[i]),
      .act(in_act), .bits(wext[i*SLICE_W +: SLICE_W]),
      .pp_q(pp_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_clr  <= 1'b0;
      s1_mask <= '0;
    end else begin
      s1_vld <= fire;
      if (fire) begin
        s1_clr  <= in_clear;
        s1_mask <= slice_en;
      end
    end
  end

  // Weighted sum of the active partial products
  always_comb begin
    prod_sum = '0;
    for (int i = 0; i < NS; i++) begin
      if (s1_mask[i]) prod_sum = prod_sum + (SUM_W'(pp_q[i]) <<< (i * SLICE_W));
    end
  end

  acc_sat #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .upd(s1_vld), .clr(s1_clr), .addend(prod_sum),
    .acc_q(acc_out), .ovf_q(acc_ovf), .valid_q(acc_valid)
  );

  // R4
  slice0_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> slice_en[0]);
  // R4
  slice_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(slice_en) == ((int'(cur_wq) + SLICE_W - 1) / SLICE_W)));
  // R5
  stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> s1_vld);
  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(s1_vld));
endmodule

// File: tb/sim_slice_mac.sv
module sim_slice_mac;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 20;
  localparam int MAXC   = 20000;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic signed [7:0] in_act = '0;
  logic [7:0] in_wgt = '0;
  logic [3:0] in_idx = '0;
  logic in_clear = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [3:0] cfg_wq = '0;
  logic signed [ACC_W-1:0] acc_out;
  logic acc_valid;
  logic acc_ovf;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int lut_m [16];
  longint m_acc = 0;
  bit m_ovf = 0;

  longint q_acc [$];
  bit     q_ovf [$];
  int     q_cyc [$];
  string  q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slice_mac #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_act(in_act), .in_wgt(in_wgt), .in_idx(in_idx), .in_clear(in_clear),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wq(cfg_wq),
    .acc_out(acc_out), .acc_valid(acc_valid), .acc_ovf(acc_ovf)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int val);
    @(negedge clk);
    in_valid = 0;
    cfg_we = 1; cfg_addr = addr[3:0]; cfg_wq = val[3:0];
    lut_m[addr] = (val == 0) ? 1 : ((val > 8) ? 8 : val);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; cfg_we = 0;
    end
  endtask

  // Driver: applies one operand and pushes the expected result
  task automatic do_op(input int act, input int w, input int idx, input bit clr, input string tag);
    int wq, wv;
    longint s, hi, lo;
    bit sat;
    @(negedge clk);
    cfg_we = 0; in_valid = 1;
    in_act = act[7:0]; in_wgt = w[7:0]; in_idx = idx[3:0]; in_clear = clr;
    wq = lut_m[idx];
    wv = w & ((1 << wq) - 1);
    if (wv >= (1 << (wq - 1))) wv = wv - (1 << wq);
    hi = (64'sd1 <<< (ACC_W - 1)) - 1;
    lo = -(64'sd1 <<< (ACC_W - 1));
    s = (clr ? 0 : m_acc) + longint'(act) * longint'(wv);
    sat = (s > hi) || (s < lo);
    m_acc = (s > hi) ? hi : ((s < lo) ? lo : s);
    m_ovf = (clr ? 1'b0 : m_ovf) | sat;
    q_acc.push_back(m_acc);
    q_ovf.push_back(m_ovf);
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
  endtask

  // Monitor: pops and compares each result as it appears (R5 timing)
  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      if (q_acc.size() == 0) begin
        check("R5 unexpected result pulse", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " acc"}, acc_out, q_acc.pop_front());
        check({t, " ovf R8"}, acc_ovf, q_ovf.pop_front());
        check({t, " cycle R5"}, cyc, q_cyc.pop_front());
      end
    end
  end

  initial begin
    repeat (MAXC) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAXC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) lut_m[e] = 8;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1 acc reset", acc_out, 0);
    check("R1 ovf reset", acc_ovf, 0);
    check("R1 valid reset", acc_valid, 0);
    check("R1 ready", in_ready, 1);

    // R2/R6: default 8-bit table entries
    do_op(5, 8'hFD, 0, 1, "R6 clear start");
    do_op(-128, 8'h80, 0, 0, "R2 neg*neg");
    do_op(-3, 127, 7, 0, "R2 max weight");
    idle(3);

    // R3: program entries, including clamps
    cfg_write(1, 3);
    cfg_write(2, 1);
    cfg_write(3, 5);
    cfg_write(4, 0);
    cfg_write(5, 15);
    // R2 junk in upper weight bits, back-to-back (R5)
    do_op(7, 8'hFD, 1, 1, "R2 wq3 junk bits");
    do_op(7, 8'h01, 2, 0, "R2 wq1 minus one");
    do_op(7, 8'hFE, 2, 0, "R2 wq1 zero");
    do_op(-9, 8'hAF, 3, 0, "R4 wq5 three slices");
    do_op(11, 8'hF3, 4, 0, "R3 clamp zero to one");
    do_op(-6, 8'h9C, 5, 0, "R3 clamp high to max");
    idle(3);

    // R3: write then use on the next cycle
    cfg_write(6, 2);
    do_op(3, 8'h06, 6, 1, "R3 write timing");
    idle(3);

    // R7/R8: positive saturation
    do_op(-128, 8'h80, 0, 1, "R7 pos run");
    for (int n = 0; n < 31; n++) do_op(-128, 8'h80, 0, 0, "R7 pos run");
    do_op(5, 8'hFD, 0, 0, "R8 ovf held");
    idle(2);
    do_op(1, 1, 0, 1, "R8 clear releases ovf");
    // R7: negative saturation
    do_op(-128, 127, 0, 1, "R7 neg run");
    for (int n = 0; n < 33; n++) do_op(-128, 127, 0, 0, "R7 neg run");
    idle(4);
    do_op(2, 8'h03, 1, 1, "R6 clear after sat");
    idle(4);
    check("R5 queue drained", q_acc.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule